// File: doc/BRIEF.md
# Signed Rounding Saturating Narrowing Shifter

This block is one step of a vector datapath. It takes a packed source vector of signed double-width elements and shifts each element right by an immediate amount, rounding to nearest. It then clamps the result to the signed range of a half-width element. Each narrowed result is written into the odd half-width lane of a destination vector. The even lanes of the destination keep the values they held before the operation. Every element is processed, because the operation has no lane masking.

A 3-bit size field and a 3-bit immediate together select the result width and the shift amount. Size code 000 is reserved and is reported as illegal. The result vector, the illegal flag and one saturation bit per element are registered when the input strobe is high, and they appear one cycle later.

Top module: `sat_round_narrow`

## Requirements
- R1: The size field decodes as follows. 001 selects 8-bit results, 01x selects 16-bit results and 1xx selects 32-bit results, where x means either bit value. Source element e occupies bits [e*2W +: 2W], where W is the result width.
- R2: The shift amount is 2W minus the unsigned 6-bit value {size, imm}. The legal shift range is therefore 1 to W.
- R3: Before an arithmetic right shift, the value 2^(shift-1) is added to the sign-extended source element. The sum has one bit of headroom, so a maximum positive source element does not wrap.
- R4: A shifted value outside [-2^(W-1), 2^(W-1)-1] is clamped to the nearer bound. The upper bound is 0x7F..F and the lower bound is 0x80..0.
- R5: The result for source element e is placed at destination lane 2e+1, which is bits [(2e+1)*W +: W].
- R6: Even destination lanes 2e, bits [2e*W +: W], are copied unchanged from the destination input.
- R7: All VLEN/(2W) elements are processed, including the highest-numbered one.
- R8: Size code 000 raises the illegal flag. The result vector then equals the destination input, and all saturation bits are zero.
- R9: Saturation bit e is 1 exactly when clamping changed the value of element e. Bits at index VLEN/(2W) and above are zero.
- R10: Outputs are captured only when in_valid is high, with a one-cycle latency. out_valid is high in the cycle after a strobe. The outputs hold their values while in_valid is low. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe that captures a new result |
| src_vec | input | VLEN | Packed signed double-width source elements |
| dst_vec | input | VLEN | Prior destination vector; its even lanes pass through |
| size_fld | input | 3 | Result-size code |
| imm_fld | input | 3 | Low immediate bits of the shift encoding |
| out_valid | output | 1 | High one cycle after a strobe |
| res_vec | output | VLEN | Merged result vector |
| illegal | output | 1 | Reserved size code was supplied |
| sat_flags | output | VLEN/16 | Per-element saturation indicator |

## Verification
Directed vectors target each stage of the datapath separately:

- **Rounding.** Values just above and just below the half-way point of a shift separate round-to-nearest from plain truncation. Negative inputs show that the shift is arithmetic.
- **Clamping.** Source values just inside and just outside the half-width range, in both signs, show whether clamping and its saturation flag fire only when needed.
- **Headroom.** The maximum positive 64-bit element at a 32-bit shift exposes a missing headroom bit, because a wrapped sum saturates to the wrong sign.
- **Decode and lane placement.** Each size code, the extreme shifts, the highest element and the reserved code check decode and lane placement.

A long run of mixed sizes, extreme and random element values, and idle cycles is then compared every clock against the behavioural model.

// File: rtl/nrw_pkg.sv
package nrw_pkg;

   typedef enum logic [1:0] {
      NRW_SZ_B   = 2'd0,
      NRW_SZ_H   = 2'd1,
      NRW_SZ_W   = 2'd2,
      NRW_SZ_BAD = 2'd3
   } nrw_size_e;

   localparam int NRW_NUM_SIZES = 3;
   localparam int NRW_MIN_W     = 8;
   localparam int NRW_SHIFT_W   = 6;

   function automatic int nrw_res_width(input int idx);
      return NRW_MIN_W << idx;
   endfunction

endpackage

// File: rtl/nrw_decode.sv
module nrw_decode
   import nrw_pkg::*;
(
   input  logic [2:0]             size_fld,
   input  logic [2:0]             imm_fld,
   output nrw_size_e              size_sel,
   output logic [NRW_SHIFT_W-1:0] shift_amt,
   output logic                   legal
);

   logic [NRW_SHIFT_W:0] code;
   logic [NRW_SHIFT_W:0] two_w;

   assign code = {1'b0, size_fld, imm_fld};

   always_comb begin
      size_sel = NRW_SZ_BAD;
      two_w    = '0;
      legal    = 1'b1;
      casez (size_fld)
         3'b001: begin size_sel = NRW_SZ_B; two_w = 7'd16; end
         3'b01?: begin size_sel = NRW_SZ_H; two_w = 7'd32; end
         3'b1??: begin size_sel = NRW_SZ_W; two_w = 7'd64; end
         default: legal = 1'b0;
      endcase
   end

   // A reserved code gets a harmless shift of 1 so the banks stay well defined.
   assign shift_amt = legal ? NRW_SHIFT_W'(two_w - code) : NRW_SHIFT_W'(1);

endmodule

// File: rtl/nrw_lane.sv
module nrw_lane
   import nrw_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [2*W-1:0]         wide_in,
   input  logic [NRW_SHIFT_W-1:0] shift_amt,
   output logic [W-1:0]           narrow_out,
   output logic                   clamped
);

   localparam int SW = 2*W + 1;     // one headroom bit above the wide element

   logic signed [SW-1:0]    ext_s;
   logic signed [SW-1:0]    bias_s;
   logic signed [SW-1:0]    sum_s;
   logic signed [SW-1:0]    shr_s;
   logic [NRW_SHIFT_W-1:0]  sh_m1;
   logic [W+1:0]            hi_bits;
   logic                    in_range;

   assign sh_m1   = shift_amt - NRW_SHIFT_W'(1);
   assign ext_s   = $signed({wide_in[2*W-1], wide_in});
   assign bias_s  = $signed(SW'(1) << sh_m1);
   assign sum_s   = ext_s + bias_s;
   assign shr_s   = sum_s >>> shift_amt;

   assign hi_bits  = shr_s[SW-1:W-1];
   assign in_range = (&hi_bits) | ~(|hi_bits);
   assign clamped  = ~in_range;

   always_comb begin
      if (in_range)
         narrow_out = shr_s[W-1:0];
      else if (shr_s[SW-1])
         narrow_out = {1'b1, {(W-1){1'b0}}};
      else
         narrow_out = {1'b0, {(W-1){1'b1}}};
   end

endmodule

// File: rtl/nrw_bank.sv
module nrw_bank
   import nrw_pkg::*;
#(
   parameter int VLEN = 128,
   parameter int W    = 8,
   parameter int NSAT = VLEN/16
) (
   input  logic [VLEN-1:0]        src_vec,
   input  logic [VLEN-1:0]        dst_vec,
   input  logic [NRW_SHIFT_W-1:0] shift_amt,
   output logic [VLEN-1:0]        merged,
   output logic [NSAT-1:0]        sat_bits
);

   localparam int NE = VLEN / (2*W);

   if (VLEN % (2*W) != 0) begin : g_bad_vlen
      $error("nrw_bank: VLEN must be a multiple of twice the result width");
   end
   if (NE > NSAT) begin : g_bad_nsat
      $error("nrw_bank: saturation vector narrower than element count");
   end

   for (genvar e = 0; e < NE; e++) begin : g_elem
      logic [W-1:0] nar;
      logic         clp;

      nrw_lane #(.W(W)) u_lane (
         .wide_in    (src_vec[e*2*W +: 2*W]),
         .shift_amt  (shift_amt),
         .narrow_out (nar),
         .clamped    (clp)
      );

      assign merged[(2*e)*W +: W]   = dst_vec[(2*e)*W +: W];
      assign merged[(2*e+1)*W +: W] = nar;
      assign sat_bits[e]            = clp;
   end

   for (genvar k = NE; k < NSAT; k++) begin : g_sat_pad
      assign sat_bits[k] = 1'b0;
   end

endmodule

// File: rtl/sat_round_narrow.sv
module sat_round_narrow
   import nrw_pkg::*;
#(
   parameter int VLEN = 128
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [VLEN-1:0]     src_vec,
   input  logic [VLEN-1:0]     dst_vec,
   input  logic [2:0]          size_fld,
   input  logic [2:0]          imm_fld,
   output logic                out_valid,
   output logic [VLEN-1:0]     res_vec,
   output logic                illegal,
   output logic [VLEN/16-1:0]  sat_flags
);

   localparam int NSAT = VLEN / 16;

   if (VLEN % 64 != 0 || VLEN < 64) begin : g_bad_vlen
      $error("sat_round_narrow: VLEN must be a positive multiple of 64");
   end

   nrw_size_e              size_sel;
   logic [NRW_SHIFT_W-1:0] shift_amt;
   logic                   legal;

   nrw_decode u_dec (
      .size_fld  (size_fld),
      .imm_fld   (imm_fld),
      .size_sel  (size_sel),
      .shift_amt (shift_amt),
      .legal     (legal)
   );

   logic [VLEN-1:0] bank_res [NRW_NUM_SIZES];
   logic [NSAT-1:0] bank_sat [NRW_NUM_SIZES];

   for (genvar g = 0; g < NRW_NUM_SIZES; g++) begin : g_size
      nrw_bank #(
         .VLEN (VLEN),
         .W    (nrw_res_width(g)),
         .NSAT (NSAT)
      ) u_bank (
         .src_vec   (src_vec),
         .dst_vec   (dst_vec),
         .shift_amt (shift_amt),
         .merged    (bank_res[g]),
         .sat_bits  (bank_sat[g])
      );
   end

   logic [VLEN-1:0] res_next;
   logic [NSAT-1:0] sat_next;

   always_comb begin
      unique case (size_sel)
         NRW_SZ_B: begin res_next = bank_res[0]; sat_next = bank_sat[0]; end
         NRW_SZ_H: begin res_next = bank_res[1]; sat_next = bank_sat[1]; end
         NRW_SZ_W: begin res_next = bank_res[2]; sat_next = bank_sat[2]; end
         default:  begin res_next = dst_vec;     sat_next = '0;          end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res_vec   <= '0;
         sat_flags <= '0;
         illegal   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            res_vec   <= res_next;
            sat_flags <= sat_next;
            illegal   <= ~legal;
         end
      end
   end

   AST_RESERVED_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && size_fld == 3'b000) |=> (illegal && res_vec == $past(dst_vec) && sat_flags == '0)); // R8

   AST_LANE0_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (res_vec[7:0] == $past(dst_vec[7:0]))); // R6

   AST_BYTE_CLAMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && size_fld == 3'b001) |=>
         (!sat_flags[0] || res_vec[15:8] == 8'h7F || res_vec[15:8] == 8'h80)); // R4

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(res_vec) && $stable(sat_flags) && $stable(illegal))); // R10

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R10

   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R10

endmodule

// File: tb/sat_round_narrow_bench.sv
`timescale 1ns/1ps
module sat_round_narrow_bench;

   localparam int VL = 128;
   localparam int NS = VL / 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [VL-1:0] src_vec = '0;
   logic [VL-1:0] dst_vec = '0;
   logic [2:0]    size_fld = '0;
   logic [2:0]    imm_fld = '0;
   logic          out_valid;
   logic [VL-1:0] res_vec;
   logic          illegal;
   logic [NS-1:0] sat_flags;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sat_round_narrow #(.VLEN(VL)) u_sat_round_narrow (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
      .src_vec (src_vec), .dst_vec (dst_vec),
      .size_fld (size_fld), .imm_fld (imm_fld),
      .out_valid (out_valid), .res_vec (res_vec),
      .illegal (illegal), .sat_flags (sat_flags)
   );

   // Behavioural reference: plain integer arithmetic per element.
   task automatic ref_op(input logic [VL-1:0] s, input logic [VL-1:0] d,
                         input logic [2:0] sz, input logic [2:0] im,
                         output logic [VL-1:0] r, output logic [NS-1:0] sat,
                         output logic ill);
      int w, sh, code;
      r = d; sat = '0; ill = 1'b0;
      if (sz == 3'b000) begin ill = 1'b1; return; end
      w    = sz[2] ? 32 : (sz[1] ? 16 : 8);
      code = {sz, im};
      sh   = 2*w - code;
      for (int e = 0; e < VL/(2*w); e++) begin
         logic [64:0]        emask;
         logic [64:0]        raw;
         logic signed [71:0] x, y, hi, lo;
         logic [VL-1:0]      lmask, lval;
         emask = (65'd1 << (2*w)) - 65'd1;
         raw   = 65'(s >> (e*2*w)) & emask;
         x     = $signed({7'd0, raw});
         if (raw[2*w-1]) x = x - (72'sd1 <<< (2*w));
         y  = (x + (72'sd1 <<< (sh-1))) >>> sh;
         hi = (72'sd1 <<< (w-1)) - 72'sd1;
         lo = -(72'sd1 <<< (w-1));
         if (y > hi) begin y = hi; sat[e] = 1'b1; end
         else if (y < lo) begin y = lo; sat[e] = 1'b1; end
         lmask = VL'((65'd1 << w) - 65'd1) << ((2*e+1)*w);
         lval  = (VL'(y[63:0]) << ((2*e+1)*w)) & lmask;
         r = (r & ~lmask) | lval;
      end
   endtask

   logic          exp_val;
   logic [VL-1:0] exp_res;
   logic [NS-1:0] exp_sat;
   logic          exp_ill;
   logic [VL-1:0] m_res;
   logic [NS-1:0] m_sat;
   logic          m_ill;

   always @(posedge clk) begin
      if (!rst_n) begin
         exp_val <= 1'b0; exp_res <= '0; exp_sat <= '0; exp_ill <= 1'b0;
      end else begin
         exp_val <= in_valid;
         if (in_valid) begin
            ref_op(src_vec, dst_vec, size_fld, imm_fld, m_res, m_sat, m_ill);
            exp_res <= m_res; exp_sat <= m_sat; exp_ill <= m_ill;
         end
      end
   end

   task automatic chk(input string tag, input logic [VL-1:0] act, input logic [VL-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // Model comparison on every clock, sampled on the falling edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R10 out_valid", VL'(out_valid), VL'(exp_val));
         chk("R5 R6 result vector", res_vec, exp_res);
         chk("R9 saturation flags", VL'(sat_flags), VL'(exp_sat));
         chk("R8 illegal flag", VL'(illegal), VL'(exp_ill));
      end
   end

   function automatic logic [VL-1:0] put(input logic [VL-1:0] v, input int ew,
                                         input int e, input logic [63:0] val);
      logic [VL-1:0] m;
      m = VL'((65'd1 << ew) - 65'd1) << (e*ew);
      return (v & ~m) | ((VL'(val) << (e*ew)) & m);
   endfunction

   task automatic apply(input logic [VL-1:0] s, input logic [VL-1:0] d,
                        input logic [2:0] sz, input logic [2:0] im);
      @(negedge clk);
      src_vec = s; dst_vec = d; size_fld = sz; imm_fld = im; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R10 watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [VL-1:0] s;
      logic [VL-1:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset result", res_vec, '0);
      chk("R10 reset valid", VL'(out_valid), '0);

      // R2 R3: shift 1 (size 001, imm 7), rounding half up, arithmetic for negatives
      d = {16{8'hAA}};
      s = '0;
      s = put(s, 16, 0, 64'h0003);
      s = put(s, 16, 1, 64'hFFFD);
      s = put(s, 16, 2, 64'h0005);
      s = put(s, 16, 7, 64'h0009);
      apply(s, d, 3'b001, 3'd7);
      chk("R3 round 3>>1", VL'(res_vec[15:8]), VL'(8'h02));
      chk("R3 round -3>>1", VL'(res_vec[31:24]), VL'(8'hFF));
      chk("R3 round 5>>1", VL'(res_vec[47:40]), VL'(8'h03));
      chk("R7 last element", VL'(res_vec[127:120]), VL'(8'h05));
      chk("R6 even lane 0", VL'(res_vec[7:0]), VL'(8'hAA));
      chk("R6 even lane 14", VL'(res_vec[119:112]), VL'(8'hAA));

      // R2: shift 8 (size 001, imm 0), boundary either side of half
      s = '0;
      s = put(s, 16, 0, 64'h0180);
      s = put(s, 16, 1, 64'h017F);
      s = put(s, 16, 2, 64'hFF80);
      s = put(s, 16, 3, 64'hFF7F);
      apply(s, '0, 3'b001, 3'd0);
      chk("R2 shift8 384", VL'(res_vec[15:8]), VL'(8'h02));
      chk("R2 shift8 383", VL'(res_vec[31:24]), VL'(8'h01));
      chk("R2 shift8 -128", VL'(res_vec[47:40]), VL'(8'h00));
      chk("R2 shift8 -129", VL'(res_vec[63:56]), VL'(8'hFF));

      // R4 R9: clamping both directions, just inside and just outside
      s = '0;
      s = put(s, 16, 0, 64'h7FFF);
      s = put(s, 16, 1, 64'h8000);
      s = put(s, 16, 2, 64'h00FE);
      s = put(s, 16, 3, 64'h00FF);
      s = put(s, 16, 4, 64'hFF00);
      s = put(s, 16, 5, 64'hFEFE);
      apply(s, '0, 3'b001, 3'd7);
      chk("R4 clamp high", VL'(res_vec[15:8]), VL'(8'h7F));
      chk("R4 clamp low", VL'(res_vec[31:24]), VL'(8'h80));
      chk("R4 inside high", VL'(res_vec[47:40]), VL'(8'h7F));
      chk("R4 inside low", VL'(res_vec[79:72]), VL'(8'h80));
      chk("R9 sat pattern", VL'(sat_flags), VL'(8'b0010_1011));

      // R1 R3: 32-bit results, shift 32, maximum positive must not wrap
      s = '0;
      s = put(s, 64, 0, 64'h7FFF_FFFF_FFFF_FFFF);
      s = put(s, 64, 1, 64'h0000_0000_8000_0000);
      d = {4{32'h1234_5678}};
      apply(s, d, 3'b100, 3'd0);
      chk("R3 headroom max positive", VL'(res_vec[63:32]), VL'(32'h7FFF_FFFF));
      chk("R1 32-bit lane 3", VL'(res_vec[127:96]), VL'(32'h0000_0001));
      chk("R6 32-bit even lane", VL'(res_vec[31:0]), VL'(32'h1234_5678));
      chk("R9 upper sat bits zero", VL'(sat_flags), VL'(8'b0000_0001));

      // R1: size 011 selects 16-bit, imm 7 gives shift 1
      s = '0;
      s = put(s, 32, 0, 64'h0000_0101);
      apply(s, '0, 3'b011, 3'd7);
      chk("R1 16-bit decode", VL'(res_vec[31:16]), VL'(16'h0081));

      // R2: size 010, imm 0 gives the widest 16-bit shift of 16
      s = '0;
      s = put(s, 32, 3, 64'h0001_8000);
      apply(s, '0, 3'b010, 3'd0);
      chk("R2 shift16", VL'(res_vec[127:112]), VL'(16'h0002));

      // R8: reserved code passes destination through
      d = {4{32'hDEAD_BEEF}};
      apply({16{8'h7F}}, d, 3'b000, 3'd5);
      chk("R8 illegal set", VL'(illegal), VL'(1'b1));
      chk("R8 passthrough", res_vec, d);

      // Mixed run: sizes, extreme and random elements, idle gaps
      for (int i = 0; i < 3000; i++) begin
         logic [VL-1:0] rs;
         logic [VL-1:0] rd;
         int pat;
         @(negedge clk);
         for (int k = 0; k < VL/32; k++) begin
            rs[k*32 +: 32] = $urandom;
            rd[k*32 +: 32] = $urandom;
         end
         pat = $urandom_range(0, 5);
         if (pat == 0) rs = {(VL/16){16'h7FFF}};
         else if (pat == 1) rs = {(VL/16){16'h8000}};
         else if (pat == 2) rs = rs & {(VL/8){8'h81}};
         src_vec  = rs;
         dst_vec  = rd;
         size_fld = 3'($urandom_range(0, 7));
         imm_fld  = 3'($urandom_range(0, 7));
         in_valid = ($urandom_range(0, 3) != 0);
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule